// File: doc/BRIEF.md
# Serial Output-Enable Slave for a Ten-Pair Clock Buffer

This block is a write-only two-wire serial slave. It keeps the output enables of a clock buffer that drives ten differential output pairs. A fast system clock oversamples the serial clock and data lines. Each line passes through a synchronizer and a short glitch filter. The block then detects START, repeated START and STOP conditions and shifts in bytes on the rising edges of the serial clock.

A write transaction has this order:
1. The fixed address byte, D2h: address 1101001 followed by a write bit of 0.
2. A command byte.
3. A byte-count byte.
4. The data bytes.

The command and byte-count bytes are acknowledged but their content is never used. Access is strictly sequential. The first data byte always loads enable register 0 and the second always loads enable register 1. Any later data bytes are acknowledged and thrown away.

The block acknowledges by pulling the data line low through an open-drain enable output. The two register values and a 10-bit per-pair enable vector go straight to the output tri-state controls of the buffer.

Top module: `oe_serial_slave`

## Requirements
- R1: After reset, `reg0_o` is FFh, `reg1_o` is C0h, `pair_en_o` is all ones (every pair enabled) and `sda_oe_o` is 0.
- R2: An address byte equal to D2h (address 1101001, write bit 0) is acknowledged. `sda_oe_o` is 1 during the ninth clock pulse and goes back to 0 after the falling edge that ends that pulse.
- R3: An address byte other than D2h is not acknowledged. This includes D3h, where the read bit is 1. The block then acknowledges no byte and changes no register until the next START.
- R4: In an addressed transaction, the command and byte-count bytes are each acknowledged, and their values have no effect on where data bytes go.
- R5: The first data byte after the byte count is written to `reg0_o` and the second to `reg1_o`. Bits 5..0 of `reg1_o` always read 0.
- R6: `pair_en_o[i]` equals `reg0_o[7-i]` for i = 0..7, `pair_en_o[8]` equals `reg1_o[7]`, and `pair_en_o[9]` equals `reg1_o[6]`. A 1 means that pair runs and a 0 means it is high impedance.
- R7: Data bytes after the second are acknowledged and leave both registers unchanged.
- R8: A STOP before the second data byte leaves unwritten registers at their old values and keeps a register written earlier. A partially received byte writes nothing.
- R9: A repeated START at any point restarts address matching, and the next transaction again writes its first data byte to `reg0_o`.
- R10: A pulse on either line that lasts fewer than three system clocks after synchronization is ignored.
- R11: Registers change only on a falling serial-clock edge that ends the eighth bit of a data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| reg0_o | output | 8 | Enable register 0 |
| reg1_o | output | 8 | Enable register 1 (bits 5..0 reserved, zero) |
| pair_en_o | output | 10 | Per-pair enable, bit i for output pair i |

## Verification
The assertions assume that the serial clock runs far slower than the system clock, so that each serial-clock phase spans many filter windows. They also assume that the master changes the data line only while the serial clock is low, except when it signals START or STOP. The bench meets both assumptions: every bit phase lasts 25 system clocks, data changes a quarter-period after each falling serial-clock edge, and glitches are injected deliberately only two clocks wide. The bench models the line as open-drain, so the line is low whenever the slave asserts `sda_oe_o`.

// File: rtl/oe_slave_pkg.sv
package oe_slave_pkg;
  localparam int NPAIR     = 10;
  localparam int R1_LIVE   = 2;   // upper bits of register 1 that are implemented

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_CMD, PH_CNT, PH_DATA} phase_t;

  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_ADDR: return PH_CMD;
      PH_CMD:  return PH_CNT;
      PH_CNT:  return PH_DATA;
      PH_DATA: return PH_DATA;
      default: return PH_IDLE;
    endcase
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a);
    return b == {a, 1'b0};
  endfunction

  function automatic logic [7:0] live_r1(input logic [7:0] b);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < R1_LIVE; i++) m[7-i] = 1'b1;
    return b & m;
  endfunction

  function automatic logic [NPAIR-1:0] map_enables(input logic [7:0] r0, input logic [7:0] r1);
    logic [NPAIR-1:0] e;
    for (int i = 0; i < 8; i++) e[i] = r0[7-i];
    for (int i = 8; i < NPAIR; i++) e[i] = r1[15-i];
    return e;
  endfunction
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   level_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)       level_q <= 1'b1;
      else if (~|hist_q) level_q <= 1'b0;
      prev_q <= level_q;
    end
  end

  assign level_o = level_q;
  assign rise_o  = level_q & ~prev_q;
  assign fall_o  = ~level_q & prev_q;
endmodule

// File: rtl/bus_engine.sv
module bus_engine
  import oe_slave_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_rise,
  input  logic       ev_fall,
  input  logic       sda_lvl,
  output logic       ack_o,
  output logic       idle_o,
  output logic [7:0] reg0_o,
  output logic [7:0] reg1_o
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  phase_t      phase_q;
  logic [3:0]  bitcnt_q;
  logic [7:0]  shreg_q;
  logic [1:0]  dcnt_q;
  logic        ack_q;
  logic [7:0]  reg0_q, reg1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      dcnt_q   <= '0;
      ack_q    <= 1'b0;
      reg0_q   <= 8'hFF;
      reg1_q   <= live_r1(8'hFF);
    end else if (ev_start) begin
      phase_q  <= PH_ADDR;
      bitcnt_q <= '0;
      dcnt_q   <= '0;
      ack_q    <= 1'b0;
    end else if (ev_stop) begin
      phase_q <= PH_IDLE;
      ack_q   <= 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (ev_rise && bitcnt_q < BITS_PER_BYTE) begin
        shreg_q  <= {shreg_q[6:0], sda_lvl};
        bitcnt_q <= bitcnt_q + 4'd1;
      end else if (ev_fall && bitcnt_q == BITS_PER_BYTE) begin
        bitcnt_q <= BITS_PER_BYTE + 4'd1;
        if (phase_q == PH_ADDR && !addr_hit(shreg_q, SLAVE_ADDR)) phase_q <= PH_IDLE;
        else ack_q <= 1'b1;
        if (phase_q == PH_DATA) begin
          if (dcnt_q == 2'd0)      reg0_q <= shreg_q;
          else if (dcnt_q == 2'd1) reg1_q <= live_r1(shreg_q);
          if (dcnt_q != 2'd2) dcnt_q <= dcnt_q + 2'd1;
        end
      end else if (ev_fall && bitcnt_q == BITS_PER_BYTE + 4'd1) begin
        ack_q    <= 1'b0;
        bitcnt_q <= '0;
        phase_q  <= next_phase(phase_q);
      end
    end
  end

  assign ack_o  = ack_q;
  assign idle_o = (phase_q == PH_IDLE);
  assign reg0_o = reg0_q;
  assign reg1_o = reg1_q;
endmodule

// File: rtl/oe_serial_slave.sv
module oe_serial_slave
  import oe_slave_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [7:0]       reg0_o,
  output logic [7:0]       reg1_o,
  output logic [NPAIR-1:0] pair_en_o
);
  localparam int NLINE = 2;   // index 0: clock line, index 1: data line

  logic [NLINE-1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(raw[g]),
      .level_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
    );
  end

  // named bus events, also observed by the checker
  logic ev_start, ev_stop, ev_scl_rise, ev_scl_fall, bus_idle;
  assign ev_scl_rise = rise[0];
  assign ev_scl_fall = fall[0];
  assign ev_start    = lvl[0] & ~rise[0] & fall[1];
  assign ev_stop     = lvl[0] & ~rise[0] & rise[1];

  bus_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_scl_rise), .ev_fall(ev_scl_fall),
    .sda_lvl(lvl[1]),
    .ack_o(sda_oe_o), .idle_o(bus_idle),
    .reg0_o(reg0_o), .reg1_o(reg1_o)
  );

  assign pair_en_o = map_enables(reg0_o, reg1_o);
endmodule

// File: rtl/oe_slave_chk.sv
module oe_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_scl_fall,
  input logic       bus_idle,
  input logic       sda_oe_o,
  input logic [7:0] reg0_o,
  input logic [7:0] reg1_o
);
  AST_ACK_RISE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(ev_scl_fall)); // R2
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> $past(ev_scl_fall || ev_start || ev_stop)); // R2
  AST_NO_ACK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(!bus_idle)); // R3
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg1_o[5:0] == 6'd0); // R5
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe_o); // R9
  AST_REG_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_scl_fall |=> ($stable(reg0_o) && $stable(reg1_o))); // R11
endmodule

bind oe_serial_slave oe_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_scl_fall(ev_scl_fall), .bus_idle(bus_idle), .sda_oe_o(sda_oe_o),
  .reg0_o(reg0_o), .reg1_o(reg1_o)
);

// File: tb/oe_serial_slave_tb.sv
module oe_serial_slave_tb_top;
  localparam int Q = 25;   // system clocks per quarter bit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [7:0] reg0, reg1;
  logic [9:0] pair_en;
  logic [7:0] exp_r0 = 8'hFF;
  logic [7:0] exp_r1 = 8'hC0;
  int n_cmp = 0;
  int n_bad = 0;
  logic timeout = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  oe_serial_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg0_o(reg0), .reg1_o(reg1), .pair_en_o(pair_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [9:0] want_en(input logic [7:0] r0, input logic [7:0] r1);
    logic [9:0] e;
    for (int i = 0; i < 8; i++) e[i] = r0[7-i];
    e[8] = r1[7];
    e[9] = r1[6];
    return e;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q); scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q); scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q); scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(2*Q);
  endtask

  // glitch: 0 none, 1 short clock pulse while low, 2 short data dip while clock high
  task automatic send_bit(input logic b, input int glitch);
    sda_m = b; wait_q(Q/2);
    if (glitch == 1) begin scl_m = 1'b1; wait_q(2); scl_m = 1'b0; end
    wait_q(Q - Q/2);
    scl_m = 1'b1; wait_q(Q);
    if (glitch == 2) begin sda_m = 1'b0; wait_q(2); sda_m = b; end
    wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked, input int glitch);
    for (int i = 7; i >= 0; i--) send_bit(b[i], (i == 2) ? glitch : 0);
    sda_m = 1'b1; wait_q(Q); scl_m = 1'b1; wait_q(Q);
    acked = !sda_line;
    wait_q(Q); scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " reg0"}, reg0, exp_r0);
    chk({tag, " reg1"}, reg1, exp_r1);
    chk({tag, " pair_en R6"}, pair_en, want_en(exp_r0, exp_r1));
  endtask

  task automatic full_write(input logic [7:0] cmd, input logic [7:0] cnt,
                            input logic [7:0] d0, input logic [7:0] d1, input string tag);
    logic a;
    bus_start();
    send_byte(8'hD2, a, 0); chk({tag, " addr ack R2"}, a, 1);
    send_byte(cmd, a, 0);   chk({tag, " cmd ack R4"}, a, 1);
    send_byte(cnt, a, 0);   chk({tag, " cnt ack R4"}, a, 1);
    send_byte(d0, a, 0);    chk({tag, " d0 ack R5"}, a, 1);
    send_byte(d1, a, 0);    chk({tag, " d1 ack R5"}, a, 1);
    wait_q(Q); chk({tag, " release R2"}, sda_oe, 0);
    bus_stop();
    exp_r0 = d0; exp_r1 = {d1[7:6], 6'd0};
    check_regs({tag, " R5"});
  endtask

  task automatic t_reset();
    chk("reset sda_oe R1", sda_oe, 0);
    chk("reset reg0 R1", reg0, 8'hFF);
    chk("reset reg1 R1", reg1, 8'hC0);
    chk("reset pair_en R1", pair_en, 10'h3FF);
  endtask

  task automatic t_basic();
    full_write(8'h00, 8'h02, 8'h80, 8'h40, "basic");
    chk("single ends R6", pair_en, 10'b10_0000_0001);
    full_write(8'hA7, 8'hFF, 8'h3C, 8'hBF, "dummy bytes R4");
    full_write(8'h11, 8'h07, 8'hFF, 8'hFF, "all on");
  endtask

  task automatic t_bad_addr(input logic [7:0] adr, input string tag);
    logic a;
    bus_start();
    send_byte(adr, a, 0); chk({tag, " no ack R3"}, a, 0);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'h00, a, 0); chk({tag, " ignored ack R3"}, a, 0);
    end
    bus_stop();
    check_regs({tag, " unchanged R3"});
  endtask

  task automatic t_extra();
    logic a;
    bus_start();
    send_byte(8'hD2, a, 0); send_byte(8'h01, a, 0); send_byte(8'h04, a, 0);
    send_byte(8'h5A, a, 0); send_byte(8'h80, a, 0);
    send_byte(8'h00, a, 0); chk("third data ack R7", a, 1);
    send_byte(8'h13, a, 0); chk("fourth data ack R7", a, 1);
    bus_stop();
    exp_r0 = 8'h5A; exp_r1 = 8'h80;
    check_regs("extra discarded R7");
  endtask

  task automatic t_stop_mid();
    logic a;
    bus_start();
    send_byte(8'hD2, a, 0); send_byte(8'h00, a, 0); send_byte(8'h02, a, 0);
    send_byte(8'h12, a, 0);
    bus_stop();
    exp_r0 = 8'h12;
    check_regs("stop after one R8");
    bus_start();
    send_byte(8'hD2, a, 0); send_byte(8'h00, a, 0); send_byte(8'h02, a, 0);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 0);
    bus_stop();
    check_regs("partial byte R8");
  endtask

  task automatic t_rstart();
    logic a;
    bus_start();
    send_byte(8'hD4, a, 0); chk("rs nack R3", a, 0);
    bus_start();
    send_byte(8'hD2, a, 0); chk("rs after nack ack R9", a, 1);
    send_byte(8'h00, a, 0); send_byte(8'h02, a, 0);
    send_byte(8'h0F, a, 0);
    bus_start();
    send_byte(8'hD2, a, 0); chk("rs mid data ack R9", a, 1);
    send_byte(8'h00, a, 0); send_byte(8'h02, a, 0);
    send_byte(8'hF0, a, 0); send_byte(8'h40, a, 0);
    bus_stop();
    exp_r0 = 8'hF0; exp_r1 = 8'h40;
    check_regs("rs restart R9");
  endtask

  task automatic t_glitch();
    logic a;
    bus_start();
    send_byte(8'hD2, a, 0); send_byte(8'h00, a, 0); send_byte(8'h02, a, 0);
    send_byte(8'hA5, a, 1); chk("scl glitch ack R10", a, 1);
    send_byte(8'hE6, a, 2); chk("sda glitch ack R10", a, 1);
    bus_stop();
    exp_r0 = 8'hA5; exp_r1 = 8'hC0;
    check_regs("glitch filtered R10");
  endtask

  task automatic run_all();
    wait_q(4); rst_n = 1'b1; wait_q(10);
    t_reset();
    t_basic();
    t_bad_addr(8'hD4, "wrong addr");
    t_bad_addr(8'hD3, "read bit");
    t_extra();
    t_stop_mid();
    t_rstart();
    t_glitch();
  endtask

  initial begin
    fork
      run_all();
      begin repeat (190000) @(posedge clk); timeout = 1'b1; end
    join_any
    if (timeout) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule